// File: doc/BRIEF.md
# Receive Sample Demapper for a Multi-Lane Converter Link

This block follows the link layer of a multi-lane 8b/10b converter receiver. In every core clock the link layer hands over one wide beat, which holds one 32-bit word per lane. The demapper unpacks that beat into sixteen 16-bit converter samples in a fixed slot order, so that downstream signal processing sees plain samples.

The packing has two levels. Inside each lane word, the octets appear in arrival order, with the earliest octet in the lowest byte. Across the bus, the lane words sit side by side, with the lowest lane in the lowest bits. Each lane word carries two consecutive samples from that lane. Converters place the two bytes of a sample on the wire in one of two orders. A configuration input selects the order. The byte-order setting is captured only in cycles that carry no beat, so the order never changes inside a burst. One register stage gives a fixed latency of one cycle.

Top module: `rx_sample_demap`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `samples_o` is all zeros.
- R2: `valid_o` equals `valid_i` from one clock earlier (latency of exactly one cycle).
- R3: Lane n is taken from `lanes_i[32n+31:32n]`, so lane 0 is in the lowest 32 bits and lane 7 in the highest.
- R4: Inside a lane word the first-arrived octet is bits [7:0], followed by [15:8], [23:16] and [31:24]. Sample k of a lane is built from octets 2k and 2k+1.
- R5: Output slot s is `samples_o[16s+15:16s]`. Slot 2n holds the earlier sample of lane n and slot 2n+1 holds the later sample.
- R6: With the byte order at 0 (low byte first), sample k is {octet 2k+1, octet 2k}. With the byte order at 1 (high byte first), it is {octet 2k, octet 2k+1}.
- R7: When `valid_i` is low in a cycle, `samples_o` keeps its value through the following cycle.
- R8: `msb_first_i` is captured at a clock edge only while `valid_i` is low, and reset sets the order to 0. A beat is decoded with the order captured most recently before it, so a change made during a burst takes effect after the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input beat qualifier |
| lanes_i | input | 256 | Concatenated lane words, lane 0 lowest |
| msb_first_i | input | 1 | Converter byte order: 1 = high byte sent first |
| valid_o | output | 1 | Output beat qualifier, one cycle after `valid_i` |
| samples_o | output | 256 | Sixteen 16-bit samples, slot 0 lowest |

## Verification
A byte-order update and a beat decode can meet at the same clock edge. The stimulus drives this case by toggling `msb_first_i` in the same cycle as a valid beat and by ending bursts with single idle cycles. The reference model applies the byte order captured at the last idle edge before each beat, so it catches a design that swaps bytes one beat too early or one beat too late. The model is checked slot by slot on every clock, and each lane octet encodes its lane and octet index, so a misrouted lane or a misplaced byte shows up directly in the compared value.

// File: rtl/rx_demap_pkg.sv
package rx_demap_pkg;
  localparam int unsigned OCTET_W = 8;

  typedef enum logic {
    ORDER_LSB_FIRST = 1'b0,
    ORDER_MSB_FIRST = 1'b1
  } byte_order_e;
endpackage

// File: rtl/rx_demap_order_reg.sv
module rx_demap_order_reg
  import rx_demap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic        msb_first_i,
  output byte_order_e order_o
);
  // Capture only on idle cycles so a burst never changes order midway.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_o <= ORDER_LSB_FIRST;
    end else if (!valid_i) begin
      order_o <= msb_first_i ? ORDER_MSB_FIRST : ORDER_LSB_FIRST;
    end
  end
endmodule

// File: rtl/rx_demap_lane.sv
module rx_demap_lane
  import rx_demap_pkg::*;
#(
  parameter int unsigned LANE_OCTETS   = 4,
  parameter int unsigned SAMPLE_OCTETS = 2,
  localparam int unsigned LANE_W       = LANE_OCTETS * OCTET_W,
  localparam int unsigned SAMPLES      = LANE_OCTETS / SAMPLE_OCTETS,
  localparam int unsigned SAMPLE_W     = SAMPLE_OCTETS * OCTET_W
) (
  input  logic [LANE_W-1:0]           lane_word_i,
  input  byte_order_e                 order_i,
  output logic [SAMPLES*SAMPLE_W-1:0] samples_o
);
  for (genvar k = 0; k < SAMPLES; k++) begin : g_smp
    for (genvar b = 0; b < SAMPLE_OCTETS; b++) begin : g_oct
      localparam int unsigned SRC_LSB = k * SAMPLE_OCTETS + b;
      localparam int unsigned SRC_MSB = k * SAMPLE_OCTETS + (SAMPLE_OCTETS - 1 - b);
      localparam int unsigned DST     = k * SAMPLE_OCTETS + b;
      always_comb begin
        if (order_i == ORDER_MSB_FIRST) begin
          samples_o[DST*OCTET_W +: OCTET_W] = lane_word_i[SRC_MSB*OCTET_W +: OCTET_W];
        end else begin
          samples_o[DST*OCTET_W +: OCTET_W] = lane_word_i[SRC_LSB*OCTET_W +: OCTET_W];
        end
      end
    end
  end
endmodule

// File: rtl/rx_demap_out_reg.sv
module rx_demap_out_reg #(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
    end else if (valid_i) begin
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/rx_sample_demap.sv
module rx_sample_demap
  import rx_demap_pkg::*;
#(
  parameter int unsigned NUM_LANES     = 8,
  parameter int unsigned LANE_OCTETS   = 4,
  parameter int unsigned SAMPLE_OCTETS = 2,
  localparam int unsigned LANE_W       = LANE_OCTETS * OCTET_W,
  localparam int unsigned BUS_W        = NUM_LANES * LANE_W,
  localparam int unsigned LANE_SMP     = LANE_OCTETS / SAMPLE_OCTETS,
  localparam int unsigned SAMPLE_W     = SAMPLE_OCTETS * OCTET_W,
  localparam int unsigned NUM_SAMPLES  = NUM_LANES * LANE_SMP,
  localparam int unsigned OUT_W        = NUM_SAMPLES * SAMPLE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] lanes_i,
  input  logic             msb_first_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] samples_o
);
  localparam int unsigned LANE_OUT_W = LANE_SMP * SAMPLE_W;

  byte_order_e      order_q;
  logic [OUT_W-1:0] mapped;

  rx_demap_order_reg u_order (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .msb_first_i (msb_first_i),
    .order_o     (order_q)
  );

  // Lane n feeds slots n*LANE_SMP .. n*LANE_SMP+LANE_SMP-1, earliest lowest.
  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    rx_demap_lane #(
      .LANE_OCTETS   (LANE_OCTETS),
      .SAMPLE_OCTETS (SAMPLE_OCTETS)
    ) u_lane (
      .lane_word_i (lanes_i[n*LANE_W +: LANE_W]),
      .order_i     (order_q),
      .samples_o   (mapped[n*LANE_OUT_W +: LANE_OUT_W])
    );
  end

  rx_demap_out_reg #(
    .DATA_W (OUT_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (mapped),
    .valid_o (valid_o),
    .data_o  (samples_o)
  );
endmodule

// File: rtl/rx_sample_demap_chk.sv
module rx_sample_demap_chk #(
  parameter int unsigned BUS_W    = 256,
  parameter int unsigned OUT_W    = 256,
  parameter int unsigned SAMPLE_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [BUS_W-1:0] lanes_i,
  input logic             order_q,
  input logic             valid_o,
  input logic [OUT_W-1:0] samples_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (!valid_o && samples_o == '0)
        else $error("R1 reset state violated");
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> valid_o == $past(valid_i));

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !valid_i |=> $stable(samples_o));

  p_order_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && valid_i |=> $stable(order_q));

  p_first_slot_lsb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !order_q |=> samples_o[SAMPLE_W-1:0] == $past(lanes_i[SAMPLE_W-1:0]));

  p_last_slot_lsb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !order_q |=>
      samples_o[OUT_W-1 -: SAMPLE_W] == $past(lanes_i[BUS_W-1 -: SAMPLE_W]));

  p_first_slot_swap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && order_q |=> samples_o[SAMPLE_W-1 -: 8] == $past(lanes_i[7:0]));
endmodule

bind rx_sample_demap rx_sample_demap_chk #(
  .BUS_W    (BUS_W),
  .OUT_W    (OUT_W),
  .SAMPLE_W (SAMPLE_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .lanes_i   (lanes_i),
  .order_q   (order_q),
  .valid_o   (valid_o),
  .samples_o (samples_o)
);

// File: tb/rx_sample_demap_tb_top.sv
module rx_sample_demap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 8;
  localparam int BUS_W      = 256;
  localparam int SLOTS      = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             valid_i;
  logic [BUS_W-1:0] lanes_i;
  logic             msb_first_i;
  logic             valid_o;
  logic [BUS_W-1:0] samples_o;

  int checks   = 0;
  int failures = 0;

  // reference model state
  bit               m_order;
  bit               m_valid;
  logic [BUS_W-1:0] m_samples;
  bit               m_swapped_beat;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rx_sample_demap dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .lanes_i     (lanes_i),
    .msb_first_i (msb_first_i),
    .valid_o     (valid_o),
    .samples_o   (samples_o)
  );

  function automatic logic [7:0] octet_of(logic [BUS_W-1:0] bus, int lane, int idx);
    return bus[lane*32 + idx*8 +: 8];
  endfunction

  // Behavioural decode straight from R3..R6.
  function automatic logic [BUS_W-1:0] expect_beat(logic [BUS_W-1:0] bus, bit hi_first);
    logic [BUS_W-1:0] r = '0;
    for (int lane = 0; lane < LANES; lane++) begin
      for (int k = 0; k < 2; k++) begin
        logic [7:0] first  = octet_of(bus, lane, 2*k);
        logic [7:0] second = octet_of(bus, lane, 2*k+1);
        int slot = 2*lane + k;
        r[slot*16 +: 16] = hi_first ? {first, second} : {second, first};
      end
    end
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] tagged_beat(int seq);
    logic [BUS_W-1:0] r;
    for (int lane = 0; lane < LANES; lane++)
      for (int o = 0; o < 4; o++)
        r[lane*32 + o*8 +: 8] = {lane[2:0], o[1:0], seq[2:0]};
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] random_beat();
    logic [BUS_W-1:0] r;
    for (int w = 0; w < BUS_W/32; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic compare(string tag);
    checks++;
    if (valid_o !== m_valid) begin
      failures++;
      $display("FAIL %s R2 valid_o actual=%0b expected=%0b", tag, valid_o, m_valid);
    end
    for (int s = 0; s < SLOTS; s++) begin
      checks++;
      if (samples_o[s*16 +: 16] !== m_samples[s*16 +: 16]) begin
        failures++;
        $display("FAIL %s %s slot %0d actual=%h expected=%h", tag,
                 m_swapped_beat ? "R6" : "R3 R4 R5", s,
                 samples_o[s*16 +: 16], m_samples[s*16 +: 16]);
      end
    end
  endtask

  // Check outputs of the previous edge, then advance model and drive inputs.
  task automatic step(bit v, logic [BUS_W-1:0] data, bit hi, string tag);
    @(negedge clk_i);
    compare(tag);
    m_valid = v;
    if (v) begin
      m_samples      = expect_beat(data, m_order);
      m_swapped_beat = m_order;
    end else begin
      m_order = hi;  // R8: order captured on idle cycles only
    end
    valid_i     = v;
    lanes_i     = data;
    msb_first_i = hi;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_ni = 1'b0; valid_i = 1'b1; lanes_i = random_beat(); msb_first_i = 1'b1;
    m_order = 0; m_valid = 0; m_samples = '0; m_swapped_beat = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      checks++;
      if (valid_o !== 1'b0 || samples_o !== '0) begin
        failures++;
        $display("FAIL R1 reset actual=%0b/%h expected=0/0", valid_o, samples_o);
      end
    end
    valid_i = 1'b0; msb_first_i = 1'b0;
    rst_ni  = 1'b1;

    // R4 R5: tagged octets, low byte first, back-to-back
    for (int i = 0; i < 6; i++) step(1, tagged_beat(i), 0, "lsb_tagged");
    // R7: idle with garbage data must not disturb samples
    for (int i = 0; i < 3; i++) step(0, random_beat(), 0, "R7 idle_hold");
    // R8: request swap during a burst; takes effect only after an idle
    step(0, '0, 0, "R8 pre");
    for (int i = 0; i < 4; i++) step(1, tagged_beat(i), 1, "R8 midstream");
    step(0, random_beat(), 1, "R8 idle_capture");
    // R6: high byte first
    for (int i = 0; i < 6; i++) step(1, tagged_beat(i+3), 0, "R6 msb_tagged");
    step(0, random_beat(), 0, "R8 back_to_lsb");
    // R3 boundary: only top / bottom lane non-zero, all-ones
    step(1, {32'hA1B2C3D4, 224'h0}, 1, "R3 top_lane");
    step(1, {224'h0, 32'h11223344}, 1, "R3 bottom_lane");
    step(1, '1, 1, "all_ones");
    // random traffic, random gaps and order requests
    for (int i = 0; i < 400; i++)
      step(($urandom % 4) != 0, random_beat(), $urandom % 2, "random");
    step(0, '0, 0, "drain");
    step(0, '0, 0, "drain");
    summary();
  end
endmodule